// File: doc/BRIEF.md
# Transmit Keying Sequencer

This block orders the events that turn a Morse key closure into transmitted RF. On key closure it first tells the local oscillators to move to their transmit frequencies. It then waits a fixed settling window before it raises the key line to the external amplifier. Only when the amplifier path returns its acknowledge does it fire the strobe that starts the RF envelope ramp-up. On key release it fires a ramp-down strobe. Once the envelope circuit reports that the ramp is finished, it drops the amplifier key line and returns the oscillators to receive.

The key input and the amplifier acknowledge are asynchronous, so each passes through its own multi-flop synchronizer. The settling window is given in microseconds and is turned into a clock-cycle count from the clock frequency parameter. The amplifier may hold off its acknowledge for any length of time; the sequencer simply waits. If the key opens before the acknowledge arrives, the exchange is abandoned with no ramp at all.

Top module: `tx_key_seq`

## Requirements
- R1: The key input passes through two synchronizer flops. A key closure that is present before clock edge 0 makes `osc_tx` rise after edge 2, with no earlier effect.
- R2: When the key closes, `osc_tx` is the first output to assert. `amp_key` stays low while the settling window runs.
- R3: `amp_key` rises exactly SETTLE_CYC clock cycles after `osc_tx` rises. SETTLE_CYC = floor(CLK_HZ*SETTLE_US/1e6), with a minimum of 1.
- R4: The acknowledge input passes through two synchronizer flops. `ramp_up` is a one-cycle strobe. It fires only while `amp_key` is high and the key is held, on the second edge after the acknowledge is sampled high.
- R5: While `amp_key` is high, any delay of the acknowledge is tolerated. `amp_key` and `osc_tx` stay high and `ramp_up` does not fire.
- R6: A key release after ramp-up produces a one-cycle `ramp_down` strobe two edges after the release is sampled. `osc_tx` and `amp_key` stay high.
- R7: After ramp-down, `osc_tx` and `amp_key` fall at the first edge at which `ramp_done` is high.
- R8: A key release during the settling window or while waiting for the acknowledge returns to idle. `osc_tx` and `amp_key` go low and neither ramp strobe fires.
- R9: Key closures during ramp-down are ignored until `ramp_done` ends the ramp-down.
- R10: Synchronous active-high `rst` drives all outputs low and returns the sequencer to idle, including from the transmitting state.
- R11: `amp_key` is never high while `osc_tx` is low, and `ramp_up` and `ramp_down` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_raw | input | 1 | Asynchronous Morse key, high = closed |
| amp_ack_raw | input | 1 | Asynchronous key acknowledge returned by the amplifier path |
| ramp_done | input | 1 | Envelope circuit reports that ramp-down is complete |
| osc_tx | output | 1 | High commands the oscillators to their transmit frequencies |
| amp_key | output | 1 | Key line to the external amplifier |
| ramp_up | output | 1 | One-cycle strobe that starts the envelope ramp-up |
| ramp_down | output | 1 | One-cycle strobe that starts the envelope ramp-down |

## Verification
The bench builds the block with CLK_HZ = 16000 and SETTLE_US = 250, which gives a four-cycle settling window. This keeps the exact osc-to-key spacing of R3 visible cycle by cycle in a short vector table. It also leaves room for a sixty-cycle acknowledge hold-off, an abort in each waiting state, a key press during ramp-down and a reset while transmitting. The synchronizer depth stays at two, so the vector table exercises the edge-exact latencies of R1 and R4.

// File: rtl/tx_key_pkg.sv
package tx_key_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SHIFT    = 3'd1,
        ST_WAIT_ACK = 3'd2,
        ST_TX       = 3'd3,
        ST_FALL     = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic osc;
        logic amp;
        logic up;
        logic dn;
    } seq_out_t;

    // Settling cycles from clock rate and window length, never below one.
    function automatic int unsigned settle_cycles(longint unsigned clk_hz,
                                                  longint unsigned win_us);
        longint unsigned c;
        c = (clk_hz * win_us) / 64'd1_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        int unsigned w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/tx_key_sync.sv
module tx_key_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tx_settle_timer.sv
module tx_settle_timer #(
    parameter int unsigned CYCLES = 4,
    parameter int unsigned CNT_W  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load)              cnt_q <= LOAD_VAL;
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R3: the window counter never leaves its loaded range
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD_VAL);

    // R3: once started, the count moves down by exactly one per cycle
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
    import tx_key_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     key_s,
    input  logic     ack_s,
    input  logic     ramp_done,
    input  logic     settle_done,
    output logic     timer_load,
    output logic     timer_run,
    output seq_out_t outs
);
    seq_state_e state_q, state_d;
    logic       up_q, dn_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (key_s) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (!key_s)           state_d = ST_IDLE;
                else if (settle_done) state_d = ST_WAIT_ACK;
            end
            ST_WAIT_ACK: begin
                if (!key_s)     state_d = ST_IDLE;
                else if (ack_s) state_d = ST_TX;
            end
            ST_TX:       if (!key_s) state_d = ST_FALL;
            ST_FALL:     if (ramp_done) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            up_q    <= 1'b0;
            dn_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            up_q    <= (state_d == ST_TX)   && (state_q != ST_TX);
            dn_q    <= (state_d == ST_FALL) && (state_q != ST_FALL);
        end
    end

    assign timer_load = (state_q == ST_IDLE);
    assign timer_run  = (state_q == ST_SHIFT);

    always_comb begin
        outs.osc = (state_q != ST_IDLE);
        outs.amp = (state_q == ST_WAIT_ACK) || (state_q == ST_TX) ||
                   (state_q == ST_FALL);
        outs.up  = up_q;
        outs.dn  = dn_q;
    end

    // R11: amplifier key only with oscillators shifted
    assert_amp_needs_osc_R11: assert property (@(posedge clk) disable iff (rst)
        outs.amp |-> outs.osc);

    // R11: ramp strobes mutually exclusive
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({outs.up, outs.dn}));

    // R2: key-out never rises in the same cycle the oscillators are commanded
    assert_shift_first_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.amp) |-> $past(outs.osc));

    // R4: ramp-up strobe lasts one cycle and only with the amplifier keyed
    assert_up_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        outs.up |-> (outs.amp && key_s) ##1 !outs.up);

    // R6: ramp-down strobe lasts one cycle
    assert_dn_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        outs.dn |=> !outs.dn);

    // R7: leaving ramp-down needs ramp_done
    assert_fall_exit_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_FALL && $fell(outs.osc)) |-> $past(ramp_done));
endmodule

// File: rtl/tx_key_seq.sv
module tx_key_seq
    import tx_key_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 125_000_000,
    parameter longint unsigned SETTLE_US   = 250,
    parameter int unsigned     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic key_raw,
    input  logic amp_ack_raw,
    input  logic ramp_done,
    output logic osc_tx,
    output logic amp_key,
    output logic ramp_up,
    output logic ramp_down
);
    localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_US);
    localparam int unsigned CNT_W      = cnt_width(SETTLE_CYC);
    localparam int unsigned N_ASYNC    = 2;

    logic [N_ASYNC-1:0] raw_v, sync_v;
    logic     timer_load, timer_run, settle_done;
    seq_out_t outs;

    assign raw_v = {amp_ack_raw, key_raw};

    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        tx_key_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk (clk),
            .rst (rst),
            .d   (raw_v[g]),
            .q   (sync_v[g])
        );
    end

    tx_settle_timer #(.CYCLES(SETTLE_CYC), .CNT_W(CNT_W)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .load (timer_load),
        .run  (timer_run),
        .done (settle_done)
    );

    tx_seq_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .key_s       (sync_v[0]),
        .ack_s       (sync_v[1]),
        .ramp_done   (ramp_done),
        .settle_done (settle_done),
        .timer_load  (timer_load),
        .timer_run   (timer_run),
        .outs        (outs)
    );

    assign osc_tx    = outs.osc;
    assign amp_key   = outs.amp;
    assign ramp_up   = outs.up;
    assign ramp_down = outs.dn;
endmodule

// File: tb/tx_key_seq_tb.sv
module tx_key_seq_tb_top;

    localparam int NV = 22;
    // Field order: key, ack, done, exp osc, exp amp, exp up, exp dn
    localparam logic [6:0] VECS [NV] = '{
        7'b100_0000, 7'b100_0000, 7'b100_1000, 7'b100_1000,
        7'b100_1000, 7'b100_1000, 7'b110_1100, 7'b110_1100,
        7'b110_1110, 7'b110_1100, 7'b010_1100, 7'b010_1100,
        7'b010_1101, 7'b010_1100, 7'b011_0000, 7'b000_0000,
        7'b100_0000, 7'b100_0000, 7'b000_1000, 7'b000_1000,
        7'b000_0000, 7'b000_0000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key_raw = 1'b0, amp_ack_raw = 1'b0, ramp_done = 1'b0;
    logic osc_tx, amp_key, ramp_up, ramp_down;
    int   checks = 0, errors = 0, inv_bad = 0, up_seen = 0, dn_seen = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    tx_key_seq #(.CLK_HZ(16000), .SETTLE_US(250), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .key_raw(key_raw), .amp_ack_raw(amp_ack_raw),
        .ramp_done(ramp_done), .osc_tx(osc_tx), .amp_key(amp_key),
        .ramp_up(ramp_up), .ramp_down(ramp_down)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if ((amp_key && !osc_tx) || (ramp_up && ramp_down)) inv_bad++;
            if (ramp_up)   up_seen++;
            if (ramp_down) dn_seen++;
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(logic k, logic a, logic d);
        key_raw = k; amp_ack_raw = a; ramp_done = d;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; key_raw = 0; amp_ack_raw = 0; ramp_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic string tag_of(int i);
        if (i <= 2)  return "R1";
        if (i <= 6)  return "R3";
        if (i <= 9)  return "R4";
        if (i <= 13) return "R6";
        if (i <= 15) return "R7";
        return "R8";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10: outputs low out of reset
        check("R10", "osc after reset", osc_tx, 0);
        check("R10", "amp after reset", amp_key, 0);
        check("R10", "strobes after reset", ramp_up | ramp_down, 0);

        // Vector walk: one cycle per entry
        for (int i = 0; i < NV; i++) begin
            step(VECS[i][6], VECS[i][5], VECS[i][4]);
            check(tag_of(i), $sformatf("vec %0d osc", i), osc_tx, VECS[i][3]);
            check(tag_of(i), $sformatf("vec %0d amp", i), amp_key, VECS[i][2]);
            check(tag_of(i), $sformatf("vec %0d up", i), ramp_up, VECS[i][1]);
            check(tag_of(i), $sformatf("vec %0d dn", i), ramp_down, VECS[i][0]);
        end

        // R2: osc first, amp held low during the window
        do_reset();
        step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
        check("R2", "osc asserted first", osc_tx, 1);
        check("R2", "amp low in window", amp_key, 0);

        // R5: long acknowledge hold-off
        for (int c = 0; c < 4; c++) step(1, 0, 0);
        check("R5", "amp keyed", amp_key, 1);
        up_seen = 0;
        for (int c = 0; c < 60; c++) step(1, 0, 0);
        check("R5", "amp held through hold-off", amp_key, 1);
        check("R5", "osc held through hold-off", osc_tx, 1);
        check("R5", "no ramp_up without ack", up_seen, 0);
        step(1, 1, 0); step(1, 1, 0); step(1, 1, 0);
        check("R4", "ramp_up after late ack", ramp_up, 1);

        // R9: key pressed again during ramp-down is ignored
        step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
        check("R6", "ramp_down after release", ramp_down, 1);
        up_seen = 0;
        for (int c = 0; c < 5; c++) step(1, 0, 0);
        check("R9", "osc held in ramp-down", osc_tx, 1);
        check("R9", "amp held in ramp-down", amp_key, 1);
        check("R9", "no ramp_up in ramp-down", up_seen, 0);
        step(0, 0, 0); step(0, 0, 0);
        step(0, 0, 1);
        check("R7", "osc released on ramp_done", osc_tx, 0);
        check("R7", "amp released on ramp_done", amp_key, 0);
        step(0, 0, 0);

        // R8: abort while waiting for acknowledge
        do_reset();
        up_seen = 0; dn_seen = 0;
        for (int c = 0; c < 7; c++) step(1, 0, 0);
        check("R8", "amp keyed before abort", amp_key, 1);
        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
        check("R8", "osc after abort", osc_tx, 0);
        check("R8", "amp after abort", amp_key, 0);
        check("R8", "no strobes on abort", up_seen + dn_seen, 0);

        // R10: reset while transmitting
        for (int c = 0; c < 7; c++) step(1, 1, 0);
        step(1, 1, 0); step(1, 1, 0);
        check("R10", "in transmit before reset", amp_key, 1);
        rst = 1'b1;
        @(negedge clk);
        check("R10", "osc cleared by reset", osc_tx, 0);
        check("R10", "amp cleared by reset", amp_key, 0);
        key_raw = 0; amp_ack_raw = 0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: invariant monitor over the whole run
        check("R11", "invariant violations", inv_bad, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule